// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block produces the clock line waveform for an I2C master. Two 9-bit programmable counts set the length of the low phase and the high phase of SCL. Both counts are measured in ticks of a count clock. The count clock is the module clock divided by 1 or by 2. The block drives SCL low through an output enable and releases it for the high phase. When a low phase ends, the block watches the sensed SCL line through a synchronizer and starts timing the high phase only once the line is actually seen high. A slow rise, or a slave that holds the clock low, therefore lengthens the bit instead of eating into the programmed high time.

The block also gives two single-cycle strobes to the byte engine that sits beside it. One marks the point in the low phase where SDA may change. The other marks the start of the high phase, where SDA is sampled. When the run request rises, the line is first held released for one high count. During this window the byte engine pulls SDA low, which forms the START condition. SCL is then driven low. Dropping the run request releases SCL on the next cycle and clears all timing state.

For standard mode, the counts should cover at least 5.0 µs low and 4.3 µs high, which includes a 0.3 µs fall allowance. For fast mode they should cover 1.6 µs low and 0.9 µs high.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and while `run` is low, `scl_oe` is 0 and both strobes are 0.
- R2: A low phase lasts exactly Nlo·D clock cycles. Its count starts in the first cycle that `scl_oe` is 1. Nlo is the effective low count and D is the division factor.
- R3: After a low phase, the high phase starts SYNC_STAGES+1 cycles after the sensed `scl_in` line goes high. With the default two-flop synchronizer, a line that rises r cycles after release gives a release window of r+3 cycles.
- R4: A high phase lasts exactly Nhi·D clock cycles, measured from its first cycle. It is then followed by a new low phase.
- R5: Each count is 9 bits. Bits 7:0 come from the count byte input and bit 8 comes from the separate top-bit input.
- R6: A count value of 0 behaves exactly like a count value of 1.
- R7: D is 1 when `div2` is 0 and 2 when `div2` is 1. Every tick-based duration scales by D.
- R8: After `run` rises, SCL stays released for Nhi·D cycles, with `hold_active` set, before the first low phase begins.
- R9: `data_change_stb` is high for one cycle in each low phase, in cycle (floor(Nlo/4)+1)·D−1 counted from the phase's first cycle (cycle 0).
- R10: `sample_stb` is high for exactly the first cycle of each high phase.
- R11: When `run` drops, `scl_oe` is 0 on the next cycle. A later run starts again from the hold window with fresh counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run request; low stops the generator and releases SCL |
| div2 | input | 1 | Count clock select: 0 = module clock, 1 = module clock / 2 |
| lo_count_byte | input | 8 | Low-phase count, bits 7:0 |
| lo_count_top | input | 1 | Low-phase count, bit 8 |
| hi_count_byte | input | 8 | High-phase count, bits 7:0 |
| hi_count_top | input | 1 | High-phase count, bit 8 |
| scl_in | input | 1 | Sensed SCL line level (asynchronous) |
| scl_oe | output | 1 | 1 = drive SCL low, 0 = release |
| hold_active | output | 1 | START hold window in progress |
| data_change_stb | output | 1 | One-cycle SDA change point in the low phase |
| sample_stb | output | 1 | One-cycle SDA sample point at high-phase start |

## Verification
The bench runs several count and line-delay patterns. Each pattern separates one effect from the others:
- Small counts at divide-by-1 pin the basic phase lengths and the strobe positions.
- The same kind of run at divide-by-2 shows whether every tick-based length doubles while the synchronizer window stays fixed.
- Zero counts and counts that use the top bit separate the minimum-one rule from the 9-bit width.
- A line that rises late shows whether the high phase is measured from the sensed rise rather than from the release.

A stop in the middle of a low phase, followed by a fresh run, shows that SCL is released at once and that timing restarts from the hold window.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  localparam int LSB_W = 8;
  localparam int CNT_W = LSB_W + 1;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_HOLD = 3'd1,
    PH_LOW  = 3'd2,
    PH_RISE = 3'd3,
    PH_HIGH = 3'd4
  } scl_phase_e;

  // Programmed count with the zero case lifted to one tick.
  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] c);
    return (c == '0) ? CNT_W'(1) : c;
  endfunction

  // Tick index inside the low phase at which SDA may change.
  function automatic logic [CNT_W-1:0] change_index(input logic [CNT_W-1:0] c);
    return eff_count(c) >> 2;
  endfunction

endpackage

// File: rtl/scl_tick_div.sv
module scl_tick_div (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic div2,
  output logic tick,
  output logic first
);
  logic pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= 1'b0;
    end else if (clear || !div2) begin
      pre_q <= 1'b0;
    end else begin
      pre_q <= ~pre_q;
    end
  end

  assign tick  = !div2 || pre_q;
  assign first = !pre_q;
endmodule

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '1;
        else        sr_q <= {sr_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sr_q[STAGES-1];
endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         tick_en,
  input  logic [W-1:0] limit,
  output logic [W-1:0] count,
  output logic         done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (tick_en) begin
      count <= count + 1'b1;
    end
  end

  assign done = tick_en && (count == limit - 1'b1);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             div2,
  input  logic [LSB_W-1:0] lo_count_byte,
  input  logic             lo_count_top,
  input  logic [LSB_W-1:0] hi_count_byte,
  input  logic             hi_count_top,
  input  logic             scl_in,
  output logic             scl_oe,
  output logic             hold_active,
  output logic             data_change_stb,
  output logic             sample_stb
);
  localparam int STW = $clog2(SYNC_STAGES + 1);
  localparam logic [STW-1:0] SETTLE_MAX = STW'(SYNC_STAGES);

  scl_phase_e phase_q, phase_d;

  logic [CNT_W-1:0] lo_full, hi_full, n_lo, n_hi, limit;
  logic [CNT_W-1:0] cnt;
  logic             cnt_done, tick, tick_first;
  logic             phase_change, counting, cnt_clear;
  logic             scl_seen_high;
  logic             phase_rise;
  logic [STW-1:0]   settle_q;
  logic             line_trusted;

  assign lo_full = {lo_count_top, lo_count_byte};
  assign hi_full = {hi_count_top, hi_count_byte};
  assign n_lo    = eff_count(lo_full);
  assign n_hi    = eff_count(hi_full);
  assign limit   = (phase_q == PH_LOW) ? n_lo : n_hi;

  scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (scl_in),
    .dout (scl_seen_high)
  );

  scl_tick_div u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(cnt_clear),
    .div2 (div2),
    .tick (tick),
    .first(tick_first)
  );

  assign counting = (phase_q == PH_HOLD) || (phase_q == PH_LOW) || (phase_q == PH_HIGH);

  scl_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (cnt_clear),
    .tick_en(tick && counting),
    .limit  (limit),
    .count  (cnt),
    .done   (cnt_done)
  );

  // Release window: wait until the synchronizer holds line samples
  // taken after the release before trusting the sensed level.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else if (phase_q != PH_RISE) begin
      settle_q <= '0;
    end else if (settle_q != SETTLE_MAX) begin
      settle_q <= settle_q + 1'b1;
    end
  end

  assign line_trusted = (settle_q == SETTLE_MAX) && scl_seen_high;

  always_comb begin
    phase_d = phase_q;
    if (!run) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE: phase_d = PH_HOLD;
        PH_HOLD: if (cnt_done) phase_d = PH_LOW;
        PH_LOW:  if (cnt_done) phase_d = PH_RISE;
        PH_RISE: if (line_trusted) phase_d = PH_HIGH;
        PH_HIGH: if (cnt_done) phase_d = PH_LOW;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  assign phase_change = (phase_d != phase_q);
  assign cnt_clear    = phase_change || (phase_q == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase_rise      = (phase_q == PH_RISE);
  assign scl_oe          = (phase_q == PH_LOW);
  assign hold_active     = (phase_q == PH_HOLD);
  assign data_change_stb = (phase_q == PH_LOW) && tick && (cnt == change_index(lo_full));
  assign sample_stb      = (phase_q == PH_HIGH) && (cnt == '0) && tick_first;
endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic scl_oe,
  input logic chg,
  input logic smp,
  input logic sync_high,
  input logic in_rise
);
  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !scl_oe);

  // R9
  chg_in_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> scl_oe);

  // R9
  chg_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !chg);

  // R10
  smp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp |=> !smp);

  // R3
  smp_after_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp |-> ($past(sync_high && in_rise) && !scl_oe));

  // R3
  rise_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rise && !sync_high && run) |=> !smp);
endmodule

bind scl_timing_gen scl_timing_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run),
  .scl_oe   (scl_oe),
  .chg      (data_change_stb),
  .smp      (sample_stb),
  .sync_high(scl_seen_high),
  .in_rise  (phase_rise)
);

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  localparam int EV_RISE = 0;
  localparam int EV_FALL = 1;
  localparam int EV_CHG  = 2;
  localparam int EV_SMP  = 3;

  typedef struct {
    int     kind;
    longint at;
    string  req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       div2 = 1'b0;
  logic [7:0] lo_b = 8'd0, hi_b = 8'd0;
  logic       lo_t = 1'b0, hi_t = 1'b0;
  logic       scl_in;
  logic       scl_oe, hold_active, chg, smp;

  longint cyc = 0;
  int     rel_cnt = 0;
  int     rise_dly = 0;
  int     checks = 0, fails = 0;
  bit     done_flag = 1'b0;
  logic   prev_oe = 1'b0;
  exp_t   ev_q[$];

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rel_cnt <= scl_oe ? 0 : ((rel_cnt < 100000) ? rel_cnt + 1 : rel_cnt);
  end

  assign scl_in = !scl_oe && (rel_cnt >= rise_dly);

  scl_timing_gen uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .run            (run),
    .div2           (div2),
    .lo_count_byte  (lo_b),
    .lo_count_top   (lo_t),
    .hi_count_byte  (hi_b),
    .hi_count_top   (hi_t),
    .scl_in         (scl_in),
    .scl_oe         (scl_oe),
    .hold_active    (hold_active),
    .data_change_stb(chg),
    .sample_stb     (smp)
  );

  function automatic string kname(int k);
    case (k)
      EV_RISE: return "scl_low_start";
      EV_FALL: return "scl_release";
      EV_CHG:  return "change_stb";
      default: return "sample_stb";
    endcase
  endfunction

  task automatic check_val(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic observe(int kind);
    exp_t e;
    checks++;
    if (ev_q.size() == 0) begin
      fails++;
      $display("FAIL unexpected event: actual %s at %0d expected none", kname(kind), cyc);
    end else begin
      e = ev_q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        fails++;
        $display("FAIL %s: actual %s at %0d expected %s at %0d",
                 e.req, kname(kind), cyc, kname(e.kind), e.at);
      end
    end
  endtask

  // Monitor: compare produced events against the scoreboard queue.
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_oe !== prev_oe) observe(scl_oe ? EV_RISE : EV_FALL);
      if (chg) observe(EV_CHG);
      if (smp) observe(EV_SMP);
      prev_oe = scl_oe;
    end
  end

  task automatic push(int kind, longint at, string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    ev_q.push_back(e);
  endtask

  task automatic idle_checks(string req);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check_val({req, " scl_oe released"}, int'(scl_oe), 0);
      check_val({req, " strobes quiet"}, int'(chg | smp | hold_active), 0);
    end
  endtask

  // Driver: program counts, predict all events of nbits bits, run, stop.
  task automatic run_case(string tag, int lo, int hi, bit d2, int r, int nbits);
    int     d, nlo, nhi, q;
    longint t, l, f, s;
    @(negedge clk);
    lo_b = lo[7:0]; lo_t = lo[8]; hi_b = hi[7:0]; hi_t = hi[8];
    div2 = d2; rise_dly = r;
    d   = d2 ? 2 : 1;
    nlo = (lo == 0) ? 1 : lo;
    nhi = (hi == 0) ? 1 : hi;
    q   = nlo / 4;
    t   = cyc + 1;
    l   = t + nhi * d;
    for (int b = 0; b < nbits; b++) begin
      push(EV_RISE, l, (b == 0) ? {tag, " R8 hold then low"} : {tag, " R4 high length"});
      push(EV_CHG, l + (q + 1) * d - 1, {tag, " R9 change point"});
      f = l + nlo * d;
      push(EV_FALL, f, {tag, " R2 low length"});
      if (b < nbits - 1) begin
        s = f + r + 3;
        push(EV_SMP, s, {tag, " R3 R10 high start after line rise"});
        l = s + nhi * d;
      end
    end
    run = 1'b1;
    @(negedge clk);
    check_val({tag, " R8 hold_active"}, int'(hold_active), 1);
    wait (ev_q.size() == 0);
    @(negedge clk);
    run = 1'b0;
    idle_checks({tag, " R11 stop"});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : main
    longint t;
    repeat (3) @(negedge clk);
    check_val("R1 reset scl_oe", int'(scl_oe), 0);
    rst_n = 1'b1;
    idle_checks("R1 idle");

    run_case("base", 5, 4, 1'b0, 0, 3);
    run_case("R7 div2", 7, 3, 1'b1, 0, 3);
    run_case("R6 zero", 0, 0, 1'b0, 0, 3);
    run_case("R5 top bit", 9'h103, 9'h101, 1'b0, 2, 2);
    run_case("R3 stretch", 8, 6, 1'b0, 10, 3);
    run_case("R7 div2 stretch", 4, 2, 1'b1, 4, 3);

    // R11: stop in the middle of a low phase
    @(negedge clk);
    lo_b = 8'd20; lo_t = 1'b0; hi_b = 8'd2; hi_t = 1'b0; div2 = 1'b0; rise_dly = 0;
    t = cyc + 1;
    push(EV_RISE, t + 2, "R11 pre-stop low start");
    push(EV_FALL, t + 6, "R11 immediate release on stop");
    run = 1'b1;
    while (cyc != t + 5) @(negedge clk);
    run = 1'b0;
    idle_checks("R11 mid-low stop");
    check_val("R11 queue drained", ev_q.size(), 0);

    // R11: restart begins again with the hold window
    run_case("R11 restart", 6, 5, 1'b0, 1, 2);

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule